// File: doc/BRIEF.md
# RAS Error Status and Header Logger

This block keeps the error record of a memory-expansion endpoint. Hardware error detectors report events on two injection ports. One port carries uncorrectable events, each with a type code and a sixteen-dword header capture. The other carries correctable events, each with only a type code. Software reads and clears the record through a small word-addressed register bus with a combinational read path.

Uncorrectable events are kept in an ordered queue, oldest first. The status register shows every type that is still pending. A first-error pointer and a sixteen-word header window always describe the oldest pending record. Software retires that record by writing back exactly its pointer bit, and the pointer and window then move on to the next record. Any other write value retires every queued record of the named types. Correctable events set sticky bits that software clears by writing ones. Every accepted event produces a one-cycle pulse, with a separate pulse line for each class, so that a message generator outside this block can report it.

A queue-occupancy state machine with three states governs the queue: `QS_EMPTY`, `QS_PEND` and `QS_FULL`. Transition `T_FIRST` (EMPTY to PEND) fires when a record enters an empty queue. `T_FILL` (PEND to FULL) fires when the last free slot is taken. `T_RELIEVE` (FULL to PEND) fires when a slot frees up. `T_DRAIN` (PEND or FULL to EMPTY) fires when the last record is retired. In `QS_EMPTY`, writes to the uncorrectable status register retire nothing.

Top module: `ras_err_logger`

## Requirements
- R1: After reset, every register reads 0, with one exception: the capability/control register (word 2) reads 31 in its pointer field, bits [5:0].
- R2: Word address map: 0 uncorrectable status, 1 uncorrectable mask, 2 capability/control, 3 correctable status, 4 correctable mask, 5 overflow flag (bit 0), and 16 to 31 header window words 0 to 15 (window word k is header bits [32k+31:32k]). Uncorrectable status reads as the OR of (1 << type) over all queued records.
- R3: An injection is discarded when its type bit is set in the matching mask register, or when its type is out of range (uncorrectable type 15 or above, correctable type 7). A discarded injection changes no status and raises no pulse.
- R4: When a record enters an empty queue, the pointer field is loaded with its type and the header window with its header. Later injections leave both unchanged.
- R5: If the queue holds records and a status write equals exactly 1 << pointer, only the oldest record is retired. The pointer and the window then load from the new oldest record, even if it has the same type as the record just retired.
- R6: Any other status write value retires every queued record whose type bit is set in it. The pointer and window reload only if the oldest record was retired. A write that matches no record changes nothing.
- R7: When the queue becomes empty, the pointer becomes 31 and the header window keeps its last contents.
- R8: The queue holds QDEPTH records (8 by default). An accepted injection into a full queue is dropped, raises no pulse and sets the overflow flag. The flag stays set until a write to word 5 with bit 0 set clears it.
- R9: Correctable status bit t is set by an unmasked injection of type t and cleared by a write of 1 to word 3 bit t. When both happen in the same cycle, the injection wins.
- R10: Each accepted uncorrectable injection drives err_unc_pulse high for exactly the cycle after it is sampled. err_cor_pulse does the same for correctable injections.
- R11: When a status write and an uncorrectable injection fall in the same cycle, the retirement is applied first and the append second, so the new record may use a slot freed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| unc_inj_valid | input | 1 | Uncorrectable event present |
| unc_inj_type | input | 4 | Uncorrectable type code (0 to 14) |
| unc_inj_hdr | input | HDR_WORDS*32 (512) | Header capture of the event |
| cor_inj_valid | input | 1 | Correctable event present |
| cor_inj_type | input | 3 | Correctable type code (0 to 6) |
| err_unc_pulse | output | 1 | One-cycle pulse per accepted uncorrectable event |
| err_cor_pulse | output | 1 | One-cycle pulse per accepted correctable event |

## Verification
The hardest situations to reach are those where the queue holds duplicate types, and the cycle in which a retirement and an append meet at a full queue. The stimulus builds them on purpose. It queues the same type twice, so that a head-only write leaves that type bit still set. It fills the queue to its depth, then pushes one more record to force the overflow. It then issues a head-retire write in the same cycle as an injection, so that the freed slot is taken at once. A behavioural model built on dynamic queues predicts the read data and both pulses on every clock.

// File: rtl/ras_pkg.sv
package ras_pkg;
    localparam int NUNC       = 15;
    localparam int NCOR       = 7;
    localparam int UTW        = 4;
    localparam int CTW        = 3;
    localparam int FEP_W      = 6;
    localparam int FEP_UNUSED = 31;

    localparam int A_UNC_STAT = 0;
    localparam int A_UNC_MASK = 1;
    localparam int A_CAPCTL   = 2;
    localparam int A_COR_STAT = 3;
    localparam int A_COR_MASK = 4;
    localparam int A_OVF      = 5;
    localparam int A_HDR_BASE = 16;

    typedef enum logic [1:0] {
        QS_EMPTY = 2'd0,
        QS_PEND  = 2'd1,
        QS_FULL  = 2'd2
    } qstate_e;
endpackage

// File: rtl/ras_unc_queue.sv
module ras_unc_queue #(
    parameter int DEPTH     = 8,
    parameter int HDR_WORDS = 16,
    parameter int TW        = 4,
    parameter int NTYPES    = 15,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int IW       = $clog2(DEPTH),
    localparam int HB       = HDR_WORDS * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TW-1:0]     push_type,
    input  logic [HB-1:0]     push_hdr,
    input  logic              rm_head,
    input  logic [NTYPES-1:0] rm_sel,
    output logic              push_ok,
    output logic              push_drop,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     cnt_nxt,
    output logic              head_new,
    output logic [TW-1:0]     head_type_nxt,
    output logic [HB-1:0]     head_hdr_nxt,
    output logic [NTYPES-1:0] type_vec
);
    logic [TW-1:0] q_type [DEPTH];
    logic [HB-1:0] q_hdr  [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] c_type [DEPTH];
    logic [HB-1:0] c_hdr  [DEPTH];
    logic [CW-1:0] c_cnt;
    logic [DEPTH-1:0] keep;

    // a record survives unless this cycle's write retires it
    for (genvar g = 0; g < DEPTH; g++) begin : g_keep
        logic sel_hit;
        always_comb begin
            sel_hit = 1'b0;
            for (int t = 0; t < NTYPES; t++) begin
                if (rm_sel[t] && (q_type[g] == TW'(t))) sel_hit = 1'b1;
            end
        end
        assign keep[g] = (CW'(g) < cnt_q) && !(rm_head ? (g == 0) : sel_hit);
    end

    // compaction of survivors toward the head, then append at the tail
    always_comb begin
        c_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            c_type[i] = '0;
            c_hdr[i]  = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                c_type[c_cnt[IW-1:0]] = q_type[i];
                c_hdr[c_cnt[IW-1:0]]  = q_hdr[i];
                c_cnt = c_cnt + CW'(1);
            end
        end
        push_ok   = push && (c_cnt < CW'(DEPTH));
        push_drop = push && !push_ok;
        if (push_ok) begin
            c_type[c_cnt[IW-1:0]] = push_type;
            c_hdr[c_cnt[IW-1:0]]  = push_hdr;
            c_cnt = c_cnt + CW'(1);
        end
    end

    always_comb begin
        type_vec = '0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int t = 0; t < NTYPES; t++) begin
                if ((CW'(i) < cnt_q) && (q_type[i] == TW'(t))) type_vec[t] = 1'b1;
            end
        end
    end

    assign head_new      = (c_cnt != '0) && !keep[0];
    assign head_type_nxt = c_type[0];
    assign head_hdr_nxt  = c_hdr[0];
    assign cnt           = cnt_q;
    assign cnt_nxt       = c_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= c_cnt;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            q_type[i] <= c_type[i];
            q_hdr[i]  <= c_hdr[i];
        end
    end
endmodule

// File: rtl/ras_cor_status.sv
module ras_cor_status #(
    parameter int NCOR = 7,
    parameter int TW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inj_valid,
    input  logic [TW-1:0]   inj_type,
    input  logic            wr_stat,
    input  logic            wr_mask,
    input  logic [NCOR-1:0] wdata,
    output logic [NCOR-1:0] stat,
    output logic [NCOR-1:0] mask,
    output logic            accept
);
    logic [NCOR-1:0] oh;
    logic [NCOR-1:0] set_vec;
    logic [NCOR-1:0] clr_vec;

    for (genvar t = 0; t < NCOR; t++) begin : g_dec
        assign oh[t] = (inj_type == TW'(t));
    end

    assign accept  = inj_valid && (|oh) && !(|(oh & mask));
    assign set_vec = accept ? oh : '0;
    assign clr_vec = wr_stat ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            mask <= '0;
        end else begin
            stat <= (stat & ~clr_vec) | set_vec;
            if (wr_mask) mask <= wdata;
        end
    end
endmodule

// File: rtl/ras_err_logger.sv
module ras_err_logger
    import ras_pkg::*;
#(
    parameter int QDEPTH    = 8,
    parameter int HDR_WORDS = 16,
    parameter int AW        = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [AW-1:0]          reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   unc_inj_valid,
    input  logic [UTW-1:0]         unc_inj_type,
    input  logic [HDR_WORDS*32-1:0] unc_inj_hdr,
    input  logic                   cor_inj_valid,
    input  logic [CTW-1:0]         cor_inj_type,
    output logic                   err_unc_pulse,
    output logic                   err_cor_pulse
);
    localparam int CW = $clog2(QDEPTH + 1);
    localparam int HB = HDR_WORDS * 32;

    qstate_e state_q, state_d;

    logic [NUNC-1:0]  unc_mask_q;
    logic [FEP_W-1:0] fep_q;
    logic [HB-1:0]    hdr_log_q;
    logic             ovf_q;

    logic wr_unc_stat, wr_unc_mask, wr_cor_stat, wr_cor_mask, wr_ovf;
    logic [NUNC-1:0] unc_oh;
    logic            unc_push;
    logic [31:0]     fep_bit;
    logic            rm_head;
    logic [NUNC-1:0] rm_sel;

    logic            push_ok, push_drop, head_new;
    logic [CW-1:0]   q_cnt, cnt_nxt;
    logic [UTW-1:0]  head_type_nxt;
    logic [HB-1:0]   head_hdr_nxt;
    logic [NUNC-1:0] unc_vec;
    logic [NCOR-1:0] cor_stat, cor_mask;
    logic            cor_accept;

    assign wr_unc_stat = reg_wr && (reg_addr == AW'(A_UNC_STAT));
    assign wr_unc_mask = reg_wr && (reg_addr == AW'(A_UNC_MASK));
    assign wr_cor_stat = reg_wr && (reg_addr == AW'(A_COR_STAT));
    assign wr_cor_mask = reg_wr && (reg_addr == AW'(A_COR_MASK));
    assign wr_ovf      = reg_wr && (reg_addr == AW'(A_OVF));

    for (genvar t = 0; t < NUNC; t++) begin : g_udec
        assign unc_oh[t] = (unc_inj_type == UTW'(t));
    end

    assign unc_push = unc_inj_valid && (|unc_oh) && !(|(unc_oh & unc_mask_q));
    assign fep_bit  = 32'd1 << fep_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QS_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_EMPTY: if (cnt_nxt != '0) state_d = QS_PEND;             // T_FIRST
            QS_PEND: begin
                if (cnt_nxt == '0)               state_d = QS_EMPTY;    // T_DRAIN
                else if (cnt_nxt == CW'(QDEPTH)) state_d = QS_FULL;     // T_FILL
            end
            QS_FULL: begin
                if (cnt_nxt == '0)               state_d = QS_EMPTY;    // T_DRAIN
                else if (cnt_nxt != CW'(QDEPTH)) state_d = QS_PEND;     // T_RELIEVE
            end
            default: state_d = QS_EMPTY;
        endcase
    end

    // outputs: retirement decode per state
    always_comb begin
        rm_head = 1'b0;
        rm_sel  = '0;
        unique case (state_q)
            QS_EMPTY: begin
                rm_head = 1'b0;
                rm_sel  = '0;
            end
            QS_PEND, QS_FULL: begin
                if (wr_unc_stat) begin
                    if (reg_wdata == fep_bit) rm_head = 1'b1;
                    else                      rm_sel  = reg_wdata[NUNC-1:0];
                end
            end
            default: begin
                rm_head = 1'b0;
                rm_sel  = '0;
            end
        endcase
    end

    ras_unc_queue #(
        .DEPTH(QDEPTH), .HDR_WORDS(HDR_WORDS), .TW(UTW), .NTYPES(NUNC)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(unc_push), .push_type(unc_inj_type), .push_hdr(unc_inj_hdr),
        .rm_head(rm_head), .rm_sel(rm_sel),
        .push_ok(push_ok), .push_drop(push_drop),
        .cnt(q_cnt), .cnt_nxt(cnt_nxt),
        .head_new(head_new), .head_type_nxt(head_type_nxt), .head_hdr_nxt(head_hdr_nxt),
        .type_vec(unc_vec)
    );

    ras_cor_status #(.NCOR(NCOR), .TW(CTW)) u_cor (
        .clk(clk), .rst_n(rst_n),
        .inj_valid(cor_inj_valid), .inj_type(cor_inj_type),
        .wr_stat(wr_cor_stat), .wr_mask(wr_cor_mask), .wdata(reg_wdata[NCOR-1:0]),
        .stat(cor_stat), .mask(cor_mask), .accept(cor_accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fep_q         <= FEP_W'(FEP_UNUSED);
            hdr_log_q     <= '0;
            unc_mask_q    <= '0;
            ovf_q         <= 1'b0;
            err_unc_pulse <= 1'b0;
            err_cor_pulse <= 1'b0;
        end else begin
            if (head_new) begin
                fep_q     <= FEP_W'(head_type_nxt);
                hdr_log_q <= head_hdr_nxt;
            end else if (state_d == QS_EMPTY) begin
                fep_q     <= FEP_W'(FEP_UNUSED);
            end
            if (wr_unc_mask) unc_mask_q <= reg_wdata[NUNC-1:0];
            if (push_drop)                   ovf_q <= 1'b1;
            else if (wr_ovf && reg_wdata[0]) ovf_q <= 1'b0;
            err_unc_pulse <= push_ok;
            err_cor_pulse <= cor_accept;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_UNC_STAT): reg_rdata = 32'(unc_vec);
            AW'(A_UNC_MASK): reg_rdata = 32'(unc_mask_q);
            AW'(A_CAPCTL):   reg_rdata = 32'(fep_q);
            AW'(A_COR_STAT): reg_rdata = 32'(cor_stat);
            AW'(A_COR_MASK): reg_rdata = 32'(cor_mask);
            AW'(A_OVF):      reg_rdata = 32'(ovf_q);
            default:         reg_rdata = '0;
        endcase
        for (int k = 0; k < HDR_WORDS; k++) begin
            if (reg_addr == AW'(A_HDR_BASE + k)) reg_rdata = hdr_log_q[k*32 +: 32];
        end
    end
endmodule

// File: rtl/ras_err_logger_chk.sv
module ras_err_logger_chk
    import ras_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int AW     = 6,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic [NCOR-1:0]  reg_wdata,
    input logic             unc_inj_valid,
    input logic [UTW-1:0]   unc_inj_type,
    input logic             err_unc_pulse,
    input logic [CW-1:0]    q_cnt,
    input logic [FEP_W-1:0] fep_q,
    input logic [NUNC-1:0]  unc_vec,
    input logic             ovf_q,
    input logic [NCOR-1:0]  cor_stat
);
    logic [NCOR-1:0] cor_clr;
    assign cor_clr = (reg_wr && reg_addr == AW'(A_COR_STAT)) ? reg_wdata : '0;

    a_r2_status_tracks_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt != '0) |-> (unc_vec != '0));

    a_r7_empty_pointer_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == '0) |-> (fep_q == FEP_W'(FEP_UNUSED)));

    a_r3_bad_type_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_inj_valid && unc_inj_type >= UTW'(NUNC)) |=> !err_unc_pulse);

    a_r10_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_unc_pulse |-> $past(unc_inj_valid));

    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= CW'(QDEPTH));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(reg_wr && reg_addr == AW'(A_OVF) && reg_wdata[0])) |=> ovf_q);

    a_r9_cor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cor_stat) & ~$past(cor_clr)) & ~cor_stat) == '0);
endmodule

bind ras_err_logger ras_err_logger_chk #(.QDEPTH(QDEPTH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata[6:0]), .unc_inj_valid(unc_inj_valid),
    .unc_inj_type(unc_inj_type), .err_unc_pulse(err_unc_pulse),
    .q_cnt(q_cnt), .fep_q(fep_q), .unc_vec(unc_vec), .ovf_q(ovf_q),
    .cor_stat(cor_stat)
);

// File: tb/tb_ras_err_logger.sv
`timescale 1ns/1ps
module tb_ras_err_logger;
    localparam int QD = 8;
    localparam int HW = 16;
    localparam int HB = HW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          unc_inj_valid = 1'b0;
    logic [3:0]    unc_inj_type = '0;
    logic [HB-1:0] unc_inj_hdr = '0;
    logic          cor_inj_valid = 1'b0;
    logic [2:0]    cor_inj_type = '0;
    logic          err_unc_pulse, err_cor_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ras_err_logger #(.QDEPTH(QD), .HDR_WORDS(HW), .AW(6)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .unc_inj_valid(unc_inj_valid), .unc_inj_type(unc_inj_type),
        .unc_inj_hdr(unc_inj_hdr), .cor_inj_valid(cor_inj_valid),
        .cor_inj_type(cor_inj_type), .err_unc_pulse(err_unc_pulse),
        .err_cor_pulse(err_cor_pulse)
    );

    // ---------------- reference model ----------------
    int            mq_t[$];
    logic [HB-1:0] mq_h[$];
    logic [14:0]   m_umask;
    logic [6:0]    m_cmask, m_cst;
    logic          m_ovf, m_up, m_cp;
    int            m_fep;
    logic [HB-1:0] m_hdr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq_t.delete(); mq_h.delete();
            m_umask = '0; m_cmask = '0; m_cst = '0; m_ovf = 0;
            m_up = 0; m_cp = 0; m_fep = 31; m_hdr = '0;
        end else begin
            int  os;
            bit  head_rm;
            bit  cacc;
            logic [6:0] ncst;
            os = mq_t.size();
            head_rm = 0;
            if (reg_wr && reg_addr == 0 && os > 0) begin
                if (reg_wdata == (32'd1 << m_fep)) begin
                    mq_t.delete(0); mq_h.delete(0); head_rm = 1;
                end else begin
                    for (int i = os - 1; i >= 0; i--) begin
                        if (reg_wdata[mq_t[i]]) begin
                            if (i == 0) head_rm = 1;
                            mq_t.delete(i); mq_h.delete(i);
                        end
                    end
                end
            end
            m_up = 0;
            if (unc_inj_valid && unc_inj_type < 15 && !m_umask[unc_inj_type]) begin
                if (mq_t.size() < QD) begin
                    mq_t.push_back(int'(unc_inj_type)); mq_h.push_back(unc_inj_hdr); m_up = 1;
                end else m_ovf = 1;
            end else if (reg_wr && reg_addr == 5 && reg_wdata[0]) m_ovf = 0;
            if (!(unc_inj_valid && unc_inj_type < 15 && !m_umask[unc_inj_type] && mq_t.size() >= QD && !m_up)
                && reg_wr && reg_addr == 5 && reg_wdata[0] && unc_inj_valid) m_ovf = m_ovf;
            if ((os == 0 || head_rm) && mq_t.size() > 0) begin
                m_fep = mq_t[0]; m_hdr = mq_h[0];
            end else if (mq_t.size() == 0) m_fep = 31;
            cacc = cor_inj_valid && cor_inj_type < 7 && !m_cmask[cor_inj_type];
            ncst = m_cst;
            if (reg_wr && reg_addr == 3) ncst = ncst & ~reg_wdata[6:0];
            if (cacc) ncst[cor_inj_type] = 1'b1;
            m_cst = ncst;
            m_cp = cacc;
            if (reg_wr && reg_addr == 1) m_umask = reg_wdata[14:0];
            if (reg_wr && reg_addr == 4) m_cmask = reg_wdata[6:0];
        end
    end

    function automatic logic [31:0] model_read(logic [5:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            6'd0: foreach (mq_t[i]) v[mq_t[i]] = 1'b1;
            6'd1: v = 32'(m_umask);
            6'd2: v = 32'(m_fep);
            6'd3: v = 32'(m_cst);
            6'd4: v = 32'(m_cmask);
            6'd5: v = 32'(m_ovf);
            default: if (a >= 16) v = m_hdr[(int'(a) - 16) * 32 +: 32];
        endcase
        return v;
    endfunction

    function automatic logic [HB-1:0] mkhdr(int s);
        logic [HB-1:0] h;
        for (int k = 0; k < HW; k++) h[k*32 +: 32] = 32'hC0DE_0000 ^ (32'(s) << 8) ^ 32'(k);
        return h;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: wait for the falling edge, compare, release strobes
    task automatic tick();
        @(negedge clk);
        chk(cur_req, reg_rdata, model_read(reg_addr));
        chk({cur_req, " R10 unc pulse"}, 32'(err_unc_pulse), 32'(m_up));
        chk({cur_req, " R10 cor pulse"}, 32'(err_cor_pulse), 32'(m_cp));
        reg_wr = 0; unc_inj_valid = 0; cor_inj_valid = 0;
    endtask

    task automatic inj_u(int t, int s);
        unc_inj_valid = 1; unc_inj_type = 4'(t); unc_inj_hdr = mkhdr(s); tick();
    endtask
    task automatic inj_c(int t);
        cor_inj_valid = 1; cor_inj_type = 3'(t); tick();
    endtask
    task automatic wr(int a, logic [31:0] d);
        reg_wr = 1; reg_addr = 6'(a); reg_wdata = d; tick();
    endtask
    task automatic rd(int a, string req, logic [31:0] exp);
        reg_addr = 6'(a); tick(); chk(req, reg_rdata, exp);
    endtask

    initial begin
        logic [HB-1:0] h;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        rd(0, "R1", 0); rd(1, "R1", 0); rd(2, "R1", 31); rd(3, "R1", 0); rd(5, "R1", 0); rd(16, "R1", 0);

        cur_req = "R2";
        inj_u(3, 1); inj_u(10, 2); inj_u(3, 3);
        rd(0, "R2", 32'h0000_0408);

        cur_req = "R4";
        h = mkhdr(1);
        rd(2, "R4", 3); rd(16, "R4", h[31:0]); rd(31, "R4", h[15*32 +: 32]);

        cur_req = "R5";
        wr(0, 32'd1 << 3);
        h = mkhdr(2);
        rd(0, "R5", 32'h0000_0408); rd(2, "R5", 10); rd(17, "R5", h[63:32]);
        wr(0, 32'd1 << 10);
        h = mkhdr(3);
        rd(0, "R5", 32'h0000_0008); rd(2, "R5", 3); rd(16, "R5", h[31:0]);

        cur_req = "R6";
        inj_u(0, 4); inj_u(14, 5); inj_u(0, 6);
        wr(0, 32'd1 << 5);
        rd(0, "R6", 32'h0000_4009);
        wr(0, 32'h0000_4001);
        rd(0, "R6", 32'h0000_0008); rd(2, "R6", 3); rd(16, "R6", h[31:0]);

        cur_req = "R7";
        wr(0, 32'h0000_0009);
        rd(0, "R7", 0); rd(2, "R7", 31); rd(16, "R7", h[31:0]);

        cur_req = "R3";
        wr(1, 32'd1 << 2);
        inj_u(2, 7);
        chk("R3 masked pulse", 32'(err_unc_pulse), 0);
        rd(0, "R3", 0); rd(2, "R3", 31);
        inj_u(15, 8);
        rd(0, "R3", 0);
        wr(4, 32'd1 << 1);
        inj_c(1);
        rd(3, "R3", 0);
        inj_c(7);
        rd(3, "R3", 0);
        wr(1, 0);

        cur_req = "R8";
        for (int t = 0; t < QD; t++) inj_u(t, 10 + t);
        rd(0, "R8", 32'h0000_00FF); rd(5, "R8", 0);
        inj_u(8, 30);
        chk("R8 dropped pulse", 32'(err_unc_pulse), 0);
        rd(0, "R8", 32'h0000_00FF); rd(5, "R8", 1);
        wr(5, 0); rd(5, "R8", 1);
        wr(5, 1); rd(5, "R8", 0);

        cur_req = "R11";
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'd1;
        unc_inj_valid = 1; unc_inj_type = 9; unc_inj_hdr = mkhdr(20);
        tick();
        rd(0, "R11", 32'h0000_02FE); rd(2, "R11", 1); rd(5, "R11", 0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, "R11", 0);
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'hFFFF_FFFF;
        unc_inj_valid = 1; unc_inj_type = 4; unc_inj_hdr = mkhdr(21);
        tick();
        h = mkhdr(21);
        rd(2, "R11", 4); rd(20, "R11", h[4*32 +: 32]);

        cur_req = "R9";
        inj_c(0); inj_c(6);
        rd(3, "R9", 32'h41);
        wr(3, 32'h1);
        rd(3, "R9", 32'h40);
        reg_wr = 1; reg_addr = 3; reg_wdata = 32'h40; cor_inj_valid = 1; cor_inj_type = 6;
        tick();
        rd(3, "R9", 32'h40);
        wr(4, 0); inj_c(1);
        rd(3, "R9", 32'h42);

        cur_req = "R10";
        reg_addr = 0;
        inj_u(5, 40);
        chk("R10 unc high", 32'(err_unc_pulse), 1);
        tick();
        chk("R10 unc low", 32'(err_unc_pulse), 0);
        inj_c(2);
        chk("R10 cor high", 32'(err_cor_pulse), 1);
        tick();
        chk("R10 cor low", 32'(err_cor_pulse), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog (R1..all) actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule